// File: doc/BRIEF.md
# Fractional Rational Clock Generator

This block derives two audio-style timing signals from a faster system clock using only synchronous logic. A 12-bit phase accumulator advances by a fixed step of 1152 on every enabled cycle and folds back by 3125 whenever the sum reaches the modulus. The ratio of these two constants is exactly 18.432/50, so a 50 MHz reference produces wrap events at an average of 18.432 MHz. Each edge can sit up to one reference period from its ideal position.

Each wrap raises a one-cycle fast strobe, and a fast square wave follows the accumulator phase. A divide-by-12 stage counts fast events and produces a 1.536 MHz square wave of 50% duty, together with a one-cycle strobe on its rising edge. The divider is a two-state machine. In state SLOW_LO the slow output is low, and in state SLOW_HI it is high. The transition SLOW_LO to SLOW_HI (the rise, which also fires the slow strobe) and the transition SLOW_HI to SLOW_LO are both taken on the sixth fast event counted since the last transition. Downstream logic should use the strobes as clock enables and should not use any output as a clock.

Top module: `frac_clkgen`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the accumulator, the 0..5 event counter and all four outputs clear to zero. Reset wins over `en`.
- R2: On the k-th enabled cycle after reset, the accumulator becomes (1152·k) mod 3125. `fast_stb` is high after that edge exactly when this value is below 1152, which means the sum wrapped. The first strobe therefore follows the third enabled cycle.
- R3: Any 3125 consecutive enabled cycles after reset hold exactly 1152 `fast_stb` pulses, and `fast_stb` is never high on two consecutive cycles.
- R4: After each enabled edge, `fast_clk` is 1 when the new accumulator value is below 1563 and 0 otherwise.
- R5: `slow_clk` toggles on every sixth fast event, and it does so in the same edge that raises `fast_stb`. With W fast events since reset, `slow_clk` equals bit 0 of floor(W/6).
- R6: `slow_stb` is high for one cycle exactly when `slow_clk` rises. This happens when a fast event brings W to a value that is 6 mod 12. Any 3125 consecutive enabled cycles hold exactly 96 of these pulses.
- R7: When `en` is low at an edge, the accumulator, the counter, `fast_clk` and `slow_clk` keep their values, and both strobes are 0.
- R8: All outputs come from flops clocked by `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (50 MHz in the intended use) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; state holds while low |
| fast_stb | output | 1 | One-cycle pulse per accumulator wrap |
| fast_clk | output | 1 | Fast square wave from the accumulator phase |
| slow_clk | output | 1 | Fast rate divided by 12, 50% duty |
| slow_stb | output | 1 | One-cycle pulse on each rise of `slow_clk` |

## Verification
A short table of vectors with an irregular `en` pattern checks each of the first twelve accumulator steps. It separates a correct step-and-fold from an off-by-one modulus, a wrong threshold, or an accumulator that moves while disabled. A free run of two full periods of 3125 enabled cycles is compared on every cycle against closed-form values of the phase. It also totals the strobes per period, which exposes drift in the step, a bad fold or a divider that counts to the wrong length. Directed tests then check reset asserted together with `en`, and a long idle stretch taken mid-period. After the idle stretch the sequence must resume exactly where it stopped.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;

    typedef enum logic {
        SLOW_LO = 1'b0,
        SLOW_HI = 1'b1
    } slow_state_e;

endpackage

// File: rtl/frac_accum.sv
module frac_accum #(
    parameter int STEP  = 1152,
    parameter int MODV  = 3125,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic             wrap,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] acc_nxt
);

    localparam logic [ACC_W:0] STEP_V = (ACC_W+1)'(STEP);
    localparam logic [ACC_W:0] MOD_V  = (ACC_W+1)'(MODV);

    logic [ACC_W:0] sum;
    logic           fold;

    always_comb begin
        sum  = {1'b0, acc_q} + STEP_V;
        fold = (sum >= MOD_V);
        if (fold) begin
            acc_nxt = ACC_W'(sum - MOD_V);
        end else begin
            acc_nxt = ACC_W'(sum);
        end
        wrap = en && fold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/fast_shaper.sv
module fast_shaper #(
    parameter int ACC_W    = 12,
    parameter int HI_LIMIT = 1563
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wrap,
    input  logic [ACC_W-1:0] acc_nxt,
    output logic             fast_stb,
    output logic             fast_clk
);

    localparam logic [ACC_W-1:0] HI_V = ACC_W'(HI_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_stb <= 1'b0;
            fast_clk <= 1'b0;
        end else begin
            fast_stb <= wrap;
            if (en) begin
                fast_clk <= (acc_nxt < HI_V);
            end
        end
    end

endmodule

// File: rtl/slow_divider.sv
module slow_divider
    import frac_clk_pkg::*;
#(
    parameter int HALF  = 6,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic slow_clk,
    output logic slow_stb
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    slow_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            rise_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rise_d  = 1'b0;
        if (tick) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                unique case (state_q)
                    SLOW_LO: begin
                        state_d = SLOW_HI;
                        rise_d  = 1'b1;
                    end
                    SLOW_HI: state_d = SLOW_LO;
                    default: state_d = SLOW_LO;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOW_LO;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_stb <= 1'b0;
        end else begin
            slow_stb <= rise_d;
        end
    end

    assign slow_clk = (state_q == SLOW_HI);

endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen #(
    parameter int STEP  = 1152,
    parameter int MODV  = 3125,
    parameter int HALF  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic fast_stb,
    output logic fast_clk,
    output logic slow_clk,
    output logic slow_stb
);

    localparam int ACC_W    = $clog2(MODV);
    localparam int HI_LIMIT = (MODV + 1) / 2;
    localparam int CNT_W    = (HALF > 1) ? $clog2(HALF) : 1;

    logic             wrap;
    logic [ACC_W-1:0] acc_val;
    logic [ACC_W-1:0] acc_nxt;

    frac_accum #(
        .STEP (STEP),
        .MODV (MODV),
        .ACC_W(ACC_W)
    ) u_accum (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .wrap   (wrap),
        .acc_q  (acc_val),
        .acc_nxt(acc_nxt)
    );

    fast_shaper #(
        .ACC_W   (ACC_W),
        .HI_LIMIT(HI_LIMIT)
    ) u_fast (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wrap    (wrap),
        .acc_nxt (acc_nxt),
        .fast_stb(fast_stb),
        .fast_clk(fast_clk)
    );

    slow_divider #(
        .HALF (HALF),
        .CNT_W(CNT_W)
    ) u_slow (
        .clk     (clk),
        .rst     (rst),
        .tick    (wrap),
        .slow_clk(slow_clk),
        .slow_stb(slow_stb)
    );

endmodule

// File: rtl/frac_clkgen_chk.sv
module frac_clkgen_chk #(
    parameter int MODV  = 3125,
    parameter int ACC_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             fast_stb,
    input logic             fast_clk,
    input logic             slow_clk,
    input logic             slow_stb,
    input logic [ACC_W-1:0] acc
);

    localparam logic [ACC_W-1:0] MOD_V = ACC_W'(MODV);

    // R2: accumulator always stays inside the modulus
    p_acc_range_r2: assert property (@(posedge clk) disable iff (rst)
        acc < MOD_V);

    // R3: never two wraps in a row
    p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (rst)
        fast_stb |=> !fast_stb);

    // R5: slow output only moves together with a fast event
    p_slow_on_fast_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(slow_clk) |-> fast_stb);

    // R6: slow strobe marks exactly the rises of the slow output
    p_stb_is_rise_r6: assert property (@(posedge clk) disable iff (rst)
        slow_stb |-> $rose(slow_clk));

    p_rise_has_stb_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_clk) |-> slow_stb);

    // R7: idle cycles keep levels and silence strobes
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(fast_clk) && $stable(slow_clk) && !fast_stb && !slow_stb));

endmodule

bind frac_clkgen frac_clkgen_chk #(
    .MODV (MODV),
    .ACC_W(ACC_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .fast_stb(fast_stb),
    .fast_clk(fast_clk),
    .slow_clk(slow_clk),
    .slow_stb(slow_stb),
    .acc     (acc_val)
);

// File: tb/test_frac_clkgen.sv
`timescale 1ns/1ps
module test_frac_clkgen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic fast_stb, fast_clk, slow_clk, slow_stb;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    longint k = 0;   // enabled steps since reset

    always #5 clk = ~clk;

    frac_clkgen i_frac_clkgen (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .fast_stb(fast_stb),
        .fast_clk(fast_clk),
        .slow_clk(slow_clk),
        .slow_stb(slow_stb)
    );

    // vector: {en, expected fast_stb, expected fast_clk}
    localparam logic [2:0] VEC [16] = '{
        3'b101, 3'b100, 3'b000, 3'b111,
        3'b001, 3'b001, 3'b101, 3'b100,
        3'b111, 3'b100, 3'b000, 3'b100,
        3'b111, 3'b100, 3'b111, 3'b101
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic e);
        en = e;
        @(posedge clk);
        #2;
        if (e && !rst) k++;
    endtask

    function automatic longint ph(input longint n);
        return (1152 * n) % 3125;
    endfunction
    function automatic longint wraps(input longint n);
        return (1152 * n) / 3125;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int m_fs, m_fl, m_sl, m_ss, n_fs, n_ss;
        logic hold_f, hold_s;
        #1;
        rst = 1'b1;
        repeat (3) cyc(1'b0);
        // R1: reset state
        check({fast_stb, fast_clk, slow_clk, slow_stb} == 4'b0, "R1 reset outputs",
              {fast_stb, fast_clk, slow_clk, slow_stb}, 0);
        rst = 1'b0;
        k = 0;

        // R2 / R4 / R7: table of early steps with gaps in en
        foreach (VEC[i]) begin
            cyc(VEC[i][2]);
            check(fast_stb == VEC[i][1], "R2 table fast_stb", fast_stb, VEC[i][1]);
            check(fast_clk == VEC[i][0], "R4 table fast_clk", fast_clk, VEC[i][0]);
        end

        // R8 / R1: reset asserted with en high clears everything
        rst = 1'b1;
        cyc(1'b1);
        cyc(1'b1);
        check({fast_stb, fast_clk, slow_clk, slow_stb} == 4'b0, "R1 R8 reset over en",
              {fast_stb, fast_clk, slow_clk, slow_stb}, 0);
        rst = 1'b0;
        k = 0;

        // two full periods compared against closed form
        for (int w = 0; w < 2; w++) begin
            m_fs = 0; m_fl = 0; m_sl = 0; m_ss = 0; n_fs = 0; n_ss = 0;
            for (int c = 0; c < 3125; c++) begin
                cyc(1'b1);
                if (fast_stb !== (ph(k) < 1152)) m_fs++;
                if (fast_clk !== (ph(k) < 1563)) m_fl++;
                if (slow_clk !== (((wraps(k) / 6) % 2) == 1)) m_sl++;
                if (slow_stb !== ((ph(k) < 1152) && (wraps(k) % 12 == 6))) m_ss++;
                if (fast_stb) n_fs++;
                if (slow_stb) n_ss++;
            end
            check(m_fs == 0, "R2 fast_stb per-cycle mismatches", m_fs, 0);
            check(m_fl == 0, "R4 fast_clk per-cycle mismatches", m_fl, 0);
            check(m_sl == 0, "R5 slow_clk per-cycle mismatches", m_sl, 0);
            check(m_ss == 0, "R6 slow_stb per-cycle mismatches", m_ss, 0);
            check(n_fs == 1152, "R3 fast strobes per period", n_fs, 1152);
            check(n_ss == 96, "R6 slow strobes per period", n_ss, 96);
        end

        // R7: idle mid-period, then resume
        while (!(slow_clk && fast_stb)) cyc(1'b1);
        hold_f = fast_clk;
        hold_s = slow_clk;
        m_fs = 0;
        for (int c = 0; c < 40; c++) begin
            cyc(1'b0);
            if (fast_stb || slow_stb || fast_clk !== hold_f || slow_clk !== hold_s) m_fs++;
        end
        check(m_fs == 0, "R7 idle hold mismatches", m_fs, 0);
        m_fs = 0;
        for (int c = 0; c < 100; c++) begin
            cyc(1'b1);
            if (fast_stb !== (ph(k) < 1152) || fast_clk !== (ph(k) < 1563) ||
                slow_clk !== (((wraps(k) / 6) % 2) == 1) ||
                slow_stb !== ((ph(k) < 1152) && (wraps(k) % 12 == 6))) m_fs++;
        end
        check(m_fs == 0, "R7 resume continues sequence", m_fs, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule